// File: doc/BRIEF.md
# Scratchpad Memory Command Engine

This block is the memory-function layer of a single-page serial EEPROM slave. The bit-level bus timing and the ROM selection layer sit outside it. What reaches it is a stream of bytes, each marked by a one-cycle valid strobe. The first byte after a bus reset is a command. The bytes after it are an address, data, or a validation key, depending on that command. When the bus master wants to read, it pulses a request line and the engine returns one byte a cycle later.

The engine holds four stores, all built from flip-flops:

- a 32-byte data scratchpad;
- a 32-byte data page;
- an 8-byte register scratchpad;
- a one-time-programmable application register.

It also holds a status byte. Writes always go to a scratchpad. A copy command, followed by the correct key, moves a whole scratchpad into its backing store. The data page can be rewritten any number of times. The application register accepts exactly one copy and then locks itself by clearing the two low status bits. Sequential transfers advance the address after every byte, wrap at the end of their store, and run until the next bus reset.

Top module: `scratch_cmd_engine`

## Requirements
- R1: After reset, the status byte reads FFh and every byte of the data page and of the application register reads 00h. A read request made before any read command leaves `tx_valid` low.
- R2: Command 0Fh is followed by a start-address byte, of which only the low 5 bits are used. Every data byte after that is stored in the data scratchpad at the current address.
- R3: Command AAh is followed by a start-address byte. After that, each `tx_req` pulse returns the data-scratchpad byte at the current address, with `tx_valid` high in the cycle after the request.
- R4: After each byte is written or read, the address advances by one. Data addresses wrap from 1Fh to 00h. Register addresses wrap from 07h to 00h.
- R5: A write or read sequence goes on for as many bytes as are sent or requested. A `bus_reset` pulse ends it, and the next byte is taken as a command.
- R6: Command 55h followed by the key byte A5h copies all 32 scratchpad bytes into the data page. Any other key byte leaves the page unchanged. Command F0h followed by a start address reads the data page, with the same timing as R3.
- R7: Command 99h followed by a start address writes the register scratchpad, using address bits [2:0]. Command C3h followed by a start address reads the application register.
- R8: Command 66h returns the status byte on every request. The status is FFh until the first accepted register copy and FCh from then on.
- R9: Command 5Ah followed by the key A5h copies the register scratchpad into the application register only while the register is unprogrammed. Any later copy leaves it unchanged.
- R10: An unrecognised command byte sends the engine to an idle state. In that state it writes nothing and returns no read bytes until `bus_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | Bus reset indication; ends the current sequence |
| rx_valid | input | 1 | One-cycle strobe marking a received byte |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Master requests the next read byte |
| tx_valid | output | 1 | Read byte valid, one cycle after `tx_req` |
| tx_byte | output | 8 | Read byte |

## Verification
The assertions rely on three properties of the inputs:

- `rx_valid` and `tx_req` are never high in the same cycle.
- `bus_reset` arrives only between bytes.
- Reset is held for several cycles, so every store has a known value before the first checked edge.

The bench drives every byte and every request as an isolated one-cycle pulse, with an idle cycle after each one, and asserts `bus_reset` only between transfers. It therefore stays inside these assumptions.

// File: rtl/scratch_cmd_pkg.sv
// Shared types for the scratchpad command engine.
package scratch_cmd_pkg;
    // Sequencer state
    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_KEY,
        ST_IDLE
    } seq_state_e;

    // Operation selected by the last command byte
    typedef enum logic [2:0] {
        OP_WR_SP,
        OP_RD_SP,
        OP_RD_MEM,
        OP_WR_REG,
        OP_RD_REG,
        OP_RD_STAT,
        OP_CP_SP,
        OP_CP_REG
    } op_e;
endpackage

// File: rtl/sc_bytes.sv
// Byte-addressed flip-flop store.
// Supports a single-byte write and a whole-array parallel load.
// Assumes ld and we are never used together to mean different things; ld wins.
module sc_bytes #(
    parameter int         N   = 32,
    parameter int         AW  = 5,
    parameter logic [7:0] RST = 8'h00
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AW-1:0]  waddr,
    input  logic [7:0]     wdata,
    input  logic           ld,
    input  logic [N*8-1:0] ld_data,
    output logic [N*8-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_byte
        // Hold one byte: reset, bulk load or addressed write
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i*8 +: 8] <= RST;
            else if (ld)
                q[i*8 +: 8] <= ld_data[i*8 +: 8];
            else if (we && waddr == AW'(i))
                q[i*8 +: 8] <= wdata;
        end
    end
endmodule

// File: rtl/sc_seq.sv
// Command sequencer.
// Decodes the command byte and tracks the wrapping address.
// Issues write, read and copy strobes.
// Assumes rx_valid and tx_req never coincide and that DDEPTH >= RDEPTH.
module sc_seq
    import scratch_cmd_pkg::*;
#(
    parameter int         DDEPTH       = 32,
    parameter int         RDEPTH       = 8,
    parameter logic [7:0] CMD_WR_SP    = 8'h0F,
    parameter logic [7:0] CMD_RD_SP    = 8'hAA,
    parameter logic [7:0] CMD_RD_MEM   = 8'hF0,
    parameter logic [7:0] CMD_WR_REG   = 8'h99,
    parameter logic [7:0] CMD_RD_REG   = 8'hC3,
    parameter logic [7:0] CMD_RD_STAT  = 8'h66,
    parameter logic [7:0] CMD_COPY_SP  = 8'h55,
    parameter logic [7:0] CMD_COPY_REG = 8'h5A,
    parameter logic [7:0] COPY_KEY     = 8'hA5,
    localparam int        AW           = $clog2(DDEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_reset,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          tx_req,
    output seq_state_e    state,
    output op_e           op,
    output logic [AW-1:0] addr,
    output logic          wr_dsp,
    output logic          wr_rsp,
    output logic          rd_fire,
    output logic          cp_sp,
    output logic          cp_reg
);
    localparam logic [AW-1:0] DMASK = AW'(DDEPTH - 1);
    localparam logic [AW-1:0] RMASK = AW'(RDEPTH - 1);

    logic          is_reg;
    logic [AW-1:0] mask;
    logic          key_ok;

    // Address mask for the store the current operation targets
    always_comb begin
        is_reg = (op == OP_WR_REG) || (op == OP_RD_REG);
        mask   = is_reg ? RMASK : DMASK;
        key_ok = rx_valid && (rx_byte == COPY_KEY) && (state == ST_KEY);
    end

    // Strobes issued towards the stores and the read path
    always_comb begin
        wr_dsp  = !bus_reset && rx_valid && (state == ST_WDATA) && (op == OP_WR_SP);
        wr_rsp  = !bus_reset && rx_valid && (state == ST_WDATA) && (op == OP_WR_REG);
        rd_fire = !bus_reset && tx_req && (state == ST_RDATA);
        cp_sp   = !bus_reset && key_ok && (op == OP_CP_SP);
        cp_reg  = !bus_reset && key_ok && (op == OP_CP_REG);
    end

    // State, operation and address register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_CMD;
            op    <= OP_RD_STAT;
            addr  <= '0;
        end else if (bus_reset) begin
            state <= ST_CMD;
        end else begin
            case (state)
                ST_CMD: if (rx_valid) begin
                    addr <= '0;
                    case (rx_byte)
                        CMD_WR_SP:    begin op <= OP_WR_SP;   state <= ST_ADDR;  end
                        CMD_RD_SP:    begin op <= OP_RD_SP;   state <= ST_ADDR;  end
                        CMD_RD_MEM:   begin op <= OP_RD_MEM;  state <= ST_ADDR;  end
                        CMD_WR_REG:   begin op <= OP_WR_REG;  state <= ST_ADDR;  end
                        CMD_RD_REG:   begin op <= OP_RD_REG;  state <= ST_ADDR;  end
                        CMD_RD_STAT:  begin op <= OP_RD_STAT; state <= ST_RDATA; end
                        CMD_COPY_SP:  begin op <= OP_CP_SP;   state <= ST_KEY;   end
                        CMD_COPY_REG: begin op <= OP_CP_REG;  state <= ST_KEY;   end
                        default:      state <= ST_IDLE;
                    endcase
                end
                ST_ADDR: if (rx_valid) begin
                    addr  <= rx_byte[AW-1:0] & mask;
                    state <= (op == OP_WR_SP || op == OP_WR_REG) ? ST_WDATA : ST_RDATA;
                end
                ST_WDATA: if (rx_valid) addr <= (addr + 1'b1) & mask;
                ST_RDATA: if (tx_req)   addr <= (addr + 1'b1) & mask;
                ST_KEY:   if (rx_valid) state <= ST_IDLE;
                default:  state <= state;
            endcase
        end
    end
endmodule

// File: rtl/scratch_cmd_engine.sv
// Memory-function engine of a single-page serial EEPROM slave.
// Owns the four stores and the status byte, and returns read bytes
// one cycle after each request.
// Assumes byte framing and the ROM layer are handled upstream.
module scratch_cmd_engine #(
    parameter int         DDEPTH       = 32,
    parameter int         RDEPTH       = 8,
    parameter logic [7:0] CMD_WR_SP    = 8'h0F,
    parameter logic [7:0] CMD_RD_SP    = 8'hAA,
    parameter logic [7:0] CMD_RD_MEM   = 8'hF0,
    parameter logic [7:0] CMD_WR_REG   = 8'h99,
    parameter logic [7:0] CMD_RD_REG   = 8'hC3,
    parameter logic [7:0] CMD_RD_STAT  = 8'h66,
    parameter logic [7:0] CMD_COPY_SP  = 8'h55,
    parameter logic [7:0] CMD_COPY_REG = 8'h5A,
    parameter logic [7:0] COPY_KEY     = 8'hA5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_reset,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       tx_req,
    output logic       tx_valid,
    output logic [7:0] tx_byte
);
    import scratch_cmd_pkg::*;

    localparam int DAW = $clog2(DDEPTH);
    localparam int RAW = $clog2(RDEPTH);

    seq_state_e        state;
    op_e               op;
    logic [DAW-1:0]    addr;
    logic              wr_dsp, wr_rsp, rd_fire, cp_sp, cp_reg;
    logic [DDEPTH*8-1:0] dsp_q, mem_q;
    logic [RDEPTH*8-1:0] rsp_q, app_q;
    logic [7:0]        status_q;
    logic              locked;
    logic              app_ld;
    logic [7:0]        rd_byte;

    sc_seq #(
        .DDEPTH(DDEPTH), .RDEPTH(RDEPTH),
        .CMD_WR_SP(CMD_WR_SP), .CMD_RD_SP(CMD_RD_SP), .CMD_RD_MEM(CMD_RD_MEM),
        .CMD_WR_REG(CMD_WR_REG), .CMD_RD_REG(CMD_RD_REG), .CMD_RD_STAT(CMD_RD_STAT),
        .CMD_COPY_SP(CMD_COPY_SP), .CMD_COPY_REG(CMD_COPY_REG), .COPY_KEY(COPY_KEY)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
        .state(state), .op(op), .addr(addr),
        .wr_dsp(wr_dsp), .wr_rsp(wr_rsp), .rd_fire(rd_fire),
        .cp_sp(cp_sp), .cp_reg(cp_reg)
    );

    sc_bytes #(.N(DDEPTH), .AW(DAW)) u_dsp (
        .clk(clk), .rst_n(rst_n), .we(wr_dsp), .waddr(addr), .wdata(rx_byte),
        .ld(1'b0), .ld_data('0), .q(dsp_q)
    );

    sc_bytes #(.N(DDEPTH), .AW(DAW)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(1'b0), .waddr('0), .wdata(8'h00),
        .ld(cp_sp), .ld_data(dsp_q), .q(mem_q)
    );

    sc_bytes #(.N(RDEPTH), .AW(RAW)) u_rsp (
        .clk(clk), .rst_n(rst_n), .we(wr_rsp), .waddr(addr[RAW-1:0]), .wdata(rx_byte),
        .ld(1'b0), .ld_data('0), .q(rsp_q)
    );

    sc_bytes #(.N(RDEPTH), .AW(RAW)) u_app (
        .clk(clk), .rst_n(rst_n), .we(1'b0), .waddr('0), .wdata(8'h00),
        .ld(app_ld), .ld_data(rsp_q), .q(app_q)
    );

    // The register copy is accepted only while unprogrammed
    always_comb begin
        locked = (status_q[1:0] == 2'b00);
        app_ld = cp_reg && !locked;
    end

    // Status byte: the two low bits clear on the first accepted copy
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= 8'hFF;
        else if (app_ld)
            status_q <= status_q & 8'hFC;
    end

    // Read-data select by operation
    always_comb begin
        case (op)
            OP_RD_SP:   rd_byte = dsp_q[addr*8 +: 8];
            OP_RD_MEM:  rd_byte = mem_q[addr*8 +: 8];
            OP_RD_REG:  rd_byte = app_q[addr[RAW-1:0]*8 +: 8];
            default:    rd_byte = status_q;
        endcase
    end

    // Registered read return, one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= 8'h00;
        end else begin
            tx_valid <= rd_fire;
            if (rd_fire) tx_byte <= rd_byte;
        end
    end
endmodule

// File: rtl/scratch_cmd_engine_chk.sv
// Property checker for scratch_cmd_engine, attached by bind.
module scratch_cmd_engine_chk #(
    parameter int         DDEPTH   = 32,
    parameter int         RDEPTH   = 8,
    parameter logic [7:0] COPY_KEY = 8'hA5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_reset,
    input logic                rx_valid,
    input logic [7:0]          rx_byte,
    input logic                tx_req,
    input logic                tx_valid,
    input logic [2:0]          state,
    input logic [7:0]          status_q,
    input logic [DDEPTH*8-1:0] mem_q,
    input logic [RDEPTH*8-1:0] app_q
);
    // R3
    tx_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(tx_req));

    // R8
    status_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == 8'hFF) || (status_q == 8'hFC));

    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == 8'hFC) |=> (status_q == 8'hFC));

    // R9
    app_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == 8'hFC) |=> $stable(app_q));

    // R6
    mem_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_q) |-> $past(rx_valid && rx_byte == COPY_KEY));

    // R5
    bus_reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (state == 3'd0));

    // R10
    idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd5) |=> !tx_valid);
endmodule

bind scratch_cmd_engine scratch_cmd_engine_chk #(
    .DDEPTH(DDEPTH), .RDEPTH(RDEPTH), .COPY_KEY(COPY_KEY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
    .tx_valid(tx_valid), .state(state), .status_q(status_q),
    .mem_q(mem_q), .app_q(app_q)
);

// File: tb/scratch_cmd_engine_test.sv
module scratch_cmd_engine_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_req = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_sp  [32];
    logic [7:0] exp_mem [32];
    logic [7:0] exp_rsp [8];
    logic [7:0] exp_app [8];

    scratch_cmd_engine uut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
        .tx_valid(tx_valid), .tx_byte(tx_byte)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic breset();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
    endtask

    // One read request; the byte is sampled at the next falling edge
    task automatic fetch(output logic v, output logic [7:0] b);
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
        v = tx_valid; b = tx_byte;
    endtask

    task automatic read_cmp(input string req, input logic [7:0] cmd, input int start,
                            input int n, input int depth, input int which);
        logic v; logic [7:0] b; logic [7:0] e;
        send(cmd); send(8'(start));
        for (int i = 0; i < n; i++) begin
            int a;
            a = (start + i) % depth;
            fetch(v, b);
            case (which)
                0: e = exp_sp[a];
                1: e = exp_mem[a];
                default: e = exp_app[a];
            endcase
            check({req, " valid"}, {7'd0, v}, 8'h01);
            check(req, b, e);
        end
        breset();
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic v; logic [7:0] b;
        for (int i = 0; i < 32; i++) begin exp_sp[i] = 8'h00; exp_mem[i] = 8'h00; end
        for (int i = 0; i < 8; i++) begin exp_rsp[i] = 8'h00; exp_app[i] = 8'h00; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        fetch(v, b); check("R1 no read before command", {7'd0, v}, 8'h00);
        send(8'h66); fetch(v, b); check("R1 status after reset", b, 8'hFF); breset();
        read_cmp("R1 page reset", 8'hF0, 0, 32, 32, 1);
        read_cmp("R1 app reset", 8'hC3, 0, 8, 8, 2);

        // R2 R4 R5: write 34 bytes from 1Eh, wrapping past 1Fh
        send(8'h0F); send(8'h1E);
        for (int i = 0; i < 34; i++) begin
            send(8'((i * 37 + 5) & 255));
            exp_sp[(30 + i) % 32] = 8'((i * 37 + 5) & 255);
        end
        breset();
        // R3 R4: read from every start address, each run crossing the wrap
        for (int s = 0; s < 32; s++) read_cmp("R3 R4 scratchpad read", 8'hAA, s, 33, 32, 0);
        // R2: upper address bits ignored (E5h -> 05h)
        send(8'h0F); send(8'hE5); send(8'h3C); exp_sp[5] = 8'h3C; breset();
        read_cmp("R2 masked address", 8'hAA, 5, 1, 32, 0);

        // R6: wrong key leaves page alone, right key copies it
        send(8'h55); send(8'h5A); breset();
        read_cmp("R6 wrong key", 8'hF0, 0, 32, 32, 1);
        send(8'h55); send(8'hA5); breset();
        for (int i = 0; i < 32; i++) exp_mem[i] = exp_sp[i];
        read_cmp("R6 page copy", 8'hF0, 3, 40, 32, 1);

        // R7 R4: register scratchpad write, 10 bytes from 06h wraps at 07h
        send(8'h99); send(8'h06);
        for (int i = 0; i < 10; i++) begin
            send(8'(8'h80 + i * 3));
            exp_rsp[(6 + i) % 8] = 8'(8'h80 + i * 3);
        end
        breset();
        send(8'h66); fetch(v, b); check("R8 status before copy", b, 8'hFF); breset();
        // R9: first copy with key takes effect
        send(8'h5A); send(8'hA5); breset();
        for (int i = 0; i < 8; i++) exp_app[i] = exp_rsp[i];
        send(8'h66);
        fetch(v, b); check("R8 status after copy", b, 8'hFC);
        fetch(v, b); check("R8 status repeated", b, 8'hFC);
        breset();
        read_cmp("R7 R4 app register read", 8'hC3, 5, 12, 8, 2);
        // R9: second copy ignored
        send(8'h99); send(8'h00);
        for (int i = 0; i < 8; i++) send(8'h11);
        breset();
        send(8'h5A); send(8'hA5); breset();
        read_cmp("R9 app unchanged", 8'hC3, 0, 8, 8, 2);
        send(8'h66); fetch(v, b); check("R9 status stays", b, 8'hFC); breset();

        // R10: unknown command ignores bytes and reads until bus reset
        send(8'h12); send(8'h0F); send(8'h00); send(8'hEE);
        fetch(v, b); check("R10 no read in idle", {7'd0, v}, 8'h00);
        breset();
        read_cmp("R10 scratchpad untouched", 8'hAA, 0, 2, 32, 0);

        // R5: write sequence cut by bus reset; next byte is a command
        send(8'h0F); send(8'h10); send(8'h77); exp_sp[16] = 8'h77;
        breset();
        send(8'hAA); send(8'h10); fetch(v, b); check("R5 command after reset", b, 8'h77);
        breset();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule